// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

The block compares two unsigned operands and reports whether the first is greater than, equal to, or less than the second. It is built from 4-bit comparison slices. Each slice settles its own nibble first. When its two nibbles are equal, it forwards the verdict it receives on its cascade inputs from the next lower slice. Chaining slices from the least significant nibble upward therefore compares any width that is a multiple of four.

The top level chains two slices into an 8-bit comparator. The cascade inputs of the lowest slice are tied to "equal" (greater=0, equal=1, less=0). From the three primary outputs the top level also derives greater-or-equal, less-or-equal and not-equal. The whole block is combinational: the outputs follow the operands with no clock and no state.

Top module: `mag_cmp8`

## Requirements
- R1: A slice asserts its greater output when its A nibble exceeds its B nibble, or when the nibbles are equal and its greater cascade input is 1.
- R2: A slice asserts its less output when its A nibble is below its B nibble, or when the nibbles are equal and its less cascade input is 1.
- R3: A slice asserts its equal output only when its nibbles are equal and its equal cascade input is 1. With equal nibbles and equal-in at 0, equal-out stays 0.
- R4: Inside a slice the most significant differing bit decides the result. For example, A=1000 and B=0111 gives greater, and A=0111 and B=1000 gives less.
- R5: When a slice's nibbles differ, its cascade inputs have no effect on any of its three outputs.
- R6: The top outputs gt_out, eq_out and lt_out match the unsigned relations a_in>b_in, a_in==b_in and a_in<b_in for every operand pair. The upper nibble dominates the lower one.
- R7: For every operand pair exactly one of gt_out, eq_out and lt_out is 1.
- R8: ge_out equals a_in>=b_in, le_out equals a_in<=b_in, and ne_out equals a_in!=b_in.
- R9: The lowest slice is seeded with equal, so two identical operands give eq_out=1 with gt_out=0 and lt_out=0, including 0x00 against 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | First unsigned operand |
| b_in | input | 8 | Second unsigned operand |
| gt_out | output | 1 | a_in is greater than b_in |
| eq_out | output | 1 | a_in equals b_in |
| lt_out | output | 1 | a_in is less than b_in |
| ge_out | output | 1 | a_in is greater than or equal to b_in |
| le_out | output | 1 | a_in is less than or equal to b_in |
| ne_out | output | 1 | a_in differs from b_in |

## Verification
The hardest situations to reach from the top ports are cascade verdicts that contradict the local nibble result, and cascade inputs with equal-in at 0. At the top the lowest slice always receives a consistent "equal" seed, so these combinations never arise there. The bench therefore also drives a standalone slice directly. It feeds that slice equal nibbles under each cascade pattern, and differing nibbles under opposing cascade verdicts. An exhaustive sweep of all 65536 operand pairs at the top covers every case where the upper slice must pass the lower slice's verdict through.

// File: rtl/cmp_pkg.sv
// Package: shared constants for the nibble-sliced magnitude comparator.
// Assumes operands are unsigned and slices are chained low to high.
package cmp_pkg;
    // Width of one comparison slice in bits.
    localparam int SLICE_W = 4;

    // Verdict seeded into the lowest slice: "so far equal".
    localparam logic SEED_GT = 1'b0;
    localparam logic SEED_EQ = 1'b1;
    localparam logic SEED_LT = 1'b0;
endpackage

// File: rtl/cmp_bit_cell.sv
// Module: one-bit comparison cell.
// Produces the bit difference and which operand wins this bit position.
// Assumes nothing about neighbouring bits; ordering is applied by the slice.
module cmp_bit_cell (
    input  logic a_bit,
    input  logic b_bit,
    output logic diff,
    output logic a_wins,
    output logic b_wins
);
    // Bits differ exactly when their XOR is 1.
    assign diff   = a_bit ^ b_bit;
    // A wins this position when it holds 1 against a 0.
    assign a_wins = a_bit & ~b_bit;
    // B wins this position when it holds 1 against a 0.
    assign b_wins = ~a_bit & b_bit;
endmodule

// File: rtl/cmp_nibble_slice.sv
// Module: cascadable unsigned slice comparator.
// Scans bits from MSB down: the first differing bit decides. If all bits
// match, the cascade inputs from the next lower slice pass through.
// Assumes cascade inputs carry a verdict from a less significant slice.
module cmp_nibble_slice #(
    parameter int SLICE_W = cmp_pkg::SLICE_W
) (
    input  logic [SLICE_W-1:0] a_nib,
    input  logic [SLICE_W-1:0] b_nib,
    input  logic               gt_in,
    input  logic               eq_in,
    input  logic               lt_in,
    output logic               gt_out,
    output logic               eq_out,
    output logic               lt_out
);
    logic [SLICE_W-1:0] bit_diff;
    logic [SLICE_W-1:0] bit_a_wins;
    logic [SLICE_W-1:0] bit_b_wins;
    // run_eq[i] is 1 when all bits above position i-1 are equal.
    logic [SLICE_W:0]   run_eq;
    logic [SLICE_W-1:0] hit_gt;
    logic [SLICE_W-1:0] hit_lt;
    logic               local_gt;
    logic               local_lt;
    logic               local_eq;

    // Equality chain starts true above the MSB.
    assign run_eq[SLICE_W] = 1'b1;

    genvar i;
    generate
        for (i = SLICE_W - 1; i >= 0; i--) begin : g_bit
            cmp_bit_cell u_cell (
                .a_bit  (a_nib[i]),
                .b_bit  (b_nib[i]),
                .diff   (bit_diff[i]),
                .a_wins (bit_a_wins[i]),
                .b_wins (bit_b_wins[i])
            );
            // Equality survives this bit only if it held above and bits match.
            assign run_eq[i] = run_eq[i+1] & ~bit_diff[i];
            // This bit decides for A only if every higher bit matched.
            assign hit_gt[i] = run_eq[i+1] & bit_a_wins[i];
            // This bit decides for B only if every higher bit matched.
            assign hit_lt[i] = run_eq[i+1] & bit_b_wins[i];
        end
    endgenerate

    // Collapse per-bit decisions into the local nibble verdict.
    always_comb begin
        local_gt = |hit_gt;
        local_lt = |hit_lt;
        local_eq = run_eq[0];
    end

    // Merge local verdict with the lower slice's verdict.
    always_comb begin
        gt_out = local_gt | (local_eq & gt_in);
        lt_out = local_lt | (local_eq & lt_in);
        eq_out = local_eq & eq_in;
    end
endmodule

// File: rtl/cmp_relations.sv
// Module: derives the combined relations from a three-way verdict.
// Assumes the verdict is one-hot, as produced by a correctly seeded chain.
module cmp_relations (
    input  logic gt,
    input  logic eq,
    input  logic lt,
    output logic ge,
    output logic le,
    output logic ne
);
    // Each combined relation is the OR of two primary verdicts.
    always_comb begin
        ge = gt | eq;
        le = lt | eq;
        ne = gt | lt;
    end
endmodule

// File: rtl/mag_cmp8.sv
// Module: unsigned magnitude comparator built from chained slices.
// Slice 0 takes the low nibble and is seeded with "equal"; each higher
// slice receives the verdict of the one below. Purely combinational.
// Assumes NIBBLES >= 1; the default gives an 8-bit comparator.
module mag_cmp8 #(
    parameter int NIBBLES = 2
) (
    input  logic [NIBBLES*cmp_pkg::SLICE_W-1:0] a_in,
    input  logic [NIBBLES*cmp_pkg::SLICE_W-1:0] b_in,
    output logic                                gt_out,
    output logic                                eq_out,
    output logic                                lt_out,
    output logic                                ge_out,
    output logic                                le_out,
    output logic                                ne_out
);
    localparam int SW = cmp_pkg::SLICE_W;

    // Verdict chain; index k feeds slice k, index NIBBLES is the result.
    logic [NIBBLES:0] gt_ch;
    logic [NIBBLES:0] eq_ch;
    logic [NIBBLES:0] lt_ch;

    // Seed the lowest slice with "equal so far".
    assign gt_ch[0] = cmp_pkg::SEED_GT;
    assign eq_ch[0] = cmp_pkg::SEED_EQ;
    assign lt_ch[0] = cmp_pkg::SEED_LT;

    genvar k;
    generate
        for (k = 0; k < NIBBLES; k++) begin : g_slice
            cmp_nibble_slice #(.SLICE_W(SW)) u_slice (
                .a_nib  (a_in[k*SW +: SW]),
                .b_nib  (b_in[k*SW +: SW]),
                .gt_in  (gt_ch[k]),
                .eq_in  (eq_ch[k]),
                .lt_in  (lt_ch[k]),
                .gt_out (gt_ch[k+1]),
                .eq_out (eq_ch[k+1]),
                .lt_out (lt_ch[k+1])
            );
        end
    endgenerate

    // Primary outputs come from the most significant slice.
    assign gt_out = gt_ch[NIBBLES];
    assign eq_out = eq_ch[NIBBLES];
    assign lt_out = lt_ch[NIBBLES];

    cmp_relations u_rel (
        .gt (gt_ch[NIBBLES]),
        .eq (eq_ch[NIBBLES]),
        .lt (lt_ch[NIBBLES]),
        .ge (ge_out),
        .le (le_out),
        .ne (ne_out)
    );
endmodule

// File: rtl/mag_cmp8_chk.sv
// Module: assertion checker for mag_cmp8, bound to every instance.
// Compares port behaviour against arithmetic relations on the operands.
module mag_cmp8_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         gt_out,
    input logic         eq_out,
    input logic         lt_out,
    input logic         ge_out,
    input logic         le_out,
    input logic         ne_out
);
    // Check the settled outputs against the operands.
    always_comb begin
        // R7
        verdict_onehot_chk: assert ($countones({gt_out, eq_out, lt_out}) == 1);
        // R6
        greater_match_chk: assert (gt_out == (a_in > b_in));
        // R6
        less_match_chk: assert (lt_out == (a_in < b_in));
        // R9
        equal_match_chk: assert (eq_out == (a_in == b_in));
        // R8
        ge_match_chk: assert (ge_out == (a_in >= b_in));
        // R8
        le_match_chk: assert (le_out == (a_in <= b_in));
        // R8
        ne_match_chk: assert (ne_out == (a_in != b_in));
    end
endmodule

bind mag_cmp8 mag_cmp8_chk #(.W(NIBBLES*cmp_pkg::SLICE_W)) u_chk (
    .a_in   (a_in),
    .b_in   (b_in),
    .gt_out (gt_out),
    .eq_out (eq_out),
    .lt_out (lt_out),
    .ge_out (ge_out),
    .le_out (le_out),
    .ne_out (ne_out)
);

// File: tb/mag_cmp8_bench.sv
// Bench: vector table, exhaustive sweep of the 8-bit top, and directed
// cascade tests on a standalone slice.
module mag_cmp8_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [7:0] a_in, b_in;
    logic gt_out, eq_out, lt_out, ge_out, le_out, ne_out;

    mag_cmp8 u_mag_cmp8 (
        .a_in(a_in), .b_in(b_in),
        .gt_out(gt_out), .eq_out(eq_out), .lt_out(lt_out),
        .ge_out(ge_out), .le_out(le_out), .ne_out(ne_out)
    );

    logic [3:0] s_a, s_b;
    logic s_gti, s_eqi, s_lti, s_gto, s_eqo, s_lto;

    cmp_nibble_slice u_slice (
        .a_nib(s_a), .b_nib(s_b),
        .gt_in(s_gti), .eq_in(s_eqi), .lt_in(s_lti),
        .gt_out(s_gto), .eq_out(s_eqo), .lt_out(s_lto)
    );

    // Vector layout: {a, b, gt, eq, lt}
    localparam logic [18:0] VEC [0:7] = '{
        {8'h80, 8'h7F, 3'b100},
        {8'h00, 8'h00, 3'b010},
        {8'h0F, 8'h10, 3'b001},
        {8'h35, 8'h34, 3'b100},
        {8'hA5, 8'hA5, 3'b010},
        {8'hFF, 8'h00, 3'b100},
        {8'h00, 8'hFF, 3'b001},
        {8'h4C, 8'h4D, 3'b001}
    };

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic slice_case(input logic [3:0] a, input logic [3:0] b,
                              input logic [2:0] cas, input logic [2:0] exp, input string req);
        @(negedge clk);
        s_a = a; s_b = b; {s_gti, s_eqi, s_lti} = cas;
        #2;
        check({s_gto, s_eqo, s_lto} == exp, req, {5'b0, s_gto, s_eqo, s_lto}, {5'b0, exp});
    endtask

    // Watchdog: an expired run is counted as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        a_in = 8'h00; b_in = 8'h00;
        s_a = 4'h0; s_b = 4'h0; {s_gti, s_eqi, s_lti} = 3'b010;

        // Initial state: equal zero operands give equal (R9)
        @(negedge clk); #2;
        check({gt_out, eq_out, lt_out} == 3'b010, "R9 zero pair", {5'b0, gt_out, eq_out, lt_out}, 8'h02);

        // Table walk (R6)
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            a_in = VEC[v][18:11]; b_in = VEC[v][10:3];
            #2;
            check({gt_out, eq_out, lt_out} == VEC[v][2:0], "R6 table",
                  {5'b0, gt_out, eq_out, lt_out}, {5'b0, VEC[v][2:0]});
        end

        // Exhaustive sweep (R6, R7, R8, R9)
        for (int p = 0; p < 65536; p++) begin
            logic [2:0] ev;
            logic [2:0] er;
            @(negedge clk);
            {a_in, b_in} = p[15:0];
            #2;
            ev = {a_in > b_in, a_in == b_in, a_in < b_in};
            er = {a_in >= b_in, a_in <= b_in, a_in != b_in};
            check({gt_out, eq_out, lt_out} == ev, "R6 sweep", {5'b0, gt_out, eq_out, lt_out}, {5'b0, ev});
            check($countones({gt_out, eq_out, lt_out}) == 1, "R7 onehot", {5'b0, gt_out, eq_out, lt_out}, 8'h00);
            check({ge_out, le_out, ne_out} == er, "R8 derived", {5'b0, ge_out, le_out, ne_out}, {5'b0, er});
        end

        // Directed slice cases
        slice_case(4'h5, 4'h5, 3'b100, 3'b100, "R1 pass greater");
        slice_case(4'h9, 4'h3, 3'b010, 3'b100, "R1 local greater");
        slice_case(4'h5, 4'h5, 3'b001, 3'b001, "R2 pass less");
        slice_case(4'h2, 4'h7, 3'b010, 3'b001, "R2 local less");
        slice_case(4'h5, 4'h5, 3'b010, 3'b010, "R3 pass equal");
        slice_case(4'h3, 4'h3, 3'b000, 3'b000, "R3 eq_in low");
        slice_case(4'h8, 4'h7, 3'b010, 3'b100, "R4 msb wins");
        slice_case(4'h7, 4'h8, 3'b010, 3'b001, "R4 msb loses");
        slice_case(4'h9, 4'h3, 3'b001, 3'b100, "R5 cascade ignored gt");
        slice_case(4'h2, 4'h7, 3'b100, 3'b001, "R5 cascade ignored lt");
        slice_case(4'hF, 4'hE, 3'b011, 3'b100, "R5 cascade ignored mixed");

        // Upper nibble dominates opposing lower nibble (R6)
        @(negedge clk);
        a_in = 8'h2F; b_in = 8'h30; #2;
        check({gt_out, eq_out, lt_out} == 3'b001, "R6 upper dominates", {5'b0, gt_out, eq_out, lt_out}, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule